// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer with a 32-bit register interface. It holds a down-counter that is loaded from one of sixteen power-of-two periods. Software keeps the system alive by writing a fixed key to a restart register before the counter runs out. When the counter does run out, the block responds in one of two ways. In direct mode it raises a system reset pulse at once. In interrupt mode it first raises an interrupt, reloads the counter, and raises the reset only if a second full period passes with the interrupt still pending.

Software programs a period index and a separate initial index, then enables the block. Enabling cannot be undone except by a reset of the block. The interrupt is acknowledged by reading a dedicated register. After the reset pulse the block stops and waits for its own reset.

The response is driven by a five-state machine. OFF: the block is disabled and the counter holds zero. ARMED: the counter runs and no interrupt is pending. WARNED: the counter runs and the interrupt is pending. FIRING: the system reset output is high. HALTED: everything is stopped.

The transitions are named as follows.
- Enable (OFF to ARMED): the counter loads the initial period.
- Kick (ARMED or WARNED to ARMED): the counter loads the selected period.
- Warn (ARMED to WARNED): first expiry in interrupt mode. The counter reloads.
- Bite (ARMED to FIRING in direct mode, or WARNED to FIRING): expiry that leads to reset.
- Acknowledge (WARNED to ARMED): a read of the acknowledge register. The counter is not reloaded.
- Done (FIRING to HALTED): the pulse length has elapsed.

When several events fall in one cycle, Kick wins over expiry, and expiry wins over Acknowledge.

Top module: `wdog_twostage`

## Requirements
- R1: After block reset all registers read zero, the counter is zero, and both `irq` and `sys_rst` are low.
- R2: The control register at offset 0x00 has two fields. Bit 0 is the enable: writing 1 sets it, and writing 0 never clears it (only block reset does). Bit 1 is the mode: 0 means direct reset, 1 means interrupt first. The mode is writable at any time, and both bits read back.
- R3: The range register at offset 0x04 holds the period index in bits [3:0] and the initial index in bits [7:4], and reads back. Index i gives a period of 2^(BASE_LOG2+i) cycles. Enabling loads the counter with 2^(BASE_LOG2+initial index)−1.
- R4: Offset 0x08 reads the current count. While ARMED or WARNED the count drops by one each cycle. Expiry happens on the clock edge at which the count is zero, so expiry comes exactly one period after a load.
- R5: Writing the 32-bit value 0x76 to offset 0x0C while the block is enabled reloads the counter with 2^(BASE_LOG2+period index)−1. It also clears a pending interrupt and returns the block to ARMED. Any other value, or the key written while the block is disabled, has no effect.
- R6: A new period index takes effect only at the next reload. The running count is not changed by the write.
- R7: In direct mode (mode = 0), expiry drives `sys_rst` high from the following cycle.
- R8: In interrupt mode (mode = 1), the first expiry raises `irq` and reloads the counter. A second expiry with the interrupt still pending lowers `irq` and raises `sys_rst`, so reset comes two periods after the last load.
- R9: Bit 0 at offset 0x10 reads the pending interrupt. A read of offset 0x14 returns the same bit and clears it. The block then returns to ARMED and keeps counting without a reload.
- R10: `sys_rst` stays high for exactly RST_CYCLES cycles (default 8). The block then halts: the count reads zero, `irq` and `sys_rst` stay low, and restart writes are ignored until block reset.
- R11: Reads from unmapped offsets return zero. Writes to the read-only offsets 0x08, 0x10 and 0x14 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally while `bus_req` is high and `bus_we` is low |
| irq | output | 1 | Interrupt pending (WARNED state) |
| sys_rst | output | 1 | System reset pulse (FIRING state) |

## Verification
The bench times each expiry to the exact edge. A design whose period is off by one cycle raises `irq` or `sys_rst` one sample early or late, and these checks catch it. The bench reads the count just after enabling and just after a kick, to show which index each load uses. A design that took the period index at enable, or reloaded the counter when the range register was written, returns the wrong count. The bench acknowledges an interrupt and then lets a full further period pass. A design that treated acknowledge as harmless would fire reset there, where the correct design only warns again. Finally, the bench writes a wrong key, writes zero to the enable, writes to read-only offsets, and kicks while OFF and while HALTED. A design that honoured any of these writes shows a changed count, enable bit or interrupt.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int IDX_W       = 4;
    localparam int NUM_PERIODS = 1 << IDX_W;
    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RANGE = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_KICK  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_ACK   = 8'h14;

    localparam logic [DATA_W-1:0] KICK_KEY = 32'h0000_0076;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ARMED,
        ST_WARNED,
        ST_FIRING,
        ST_HALTED
    } wd_state_e;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CW = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CW-1:0]     cnt,
    input  logic              irq,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              en,
    output logic              mode,
    output logic [IDX_W-1:0]  top_idx,
    output logic [IDX_W-1:0]  init_idx,
    output logic              en_set,
    output logic              kick,
    output logic              ack_rd
);

    logic wr, rd;

    assign wr = bus_req &&  bus_we;
    assign rd = bus_req && !bus_we;

    // Strobes towards the state machine
    assign en_set = wr && (bus_addr == OFS_CTRL) && bus_wdata[0] && !en;
    assign kick   = wr && (bus_addr == OFS_KICK) && (bus_wdata == KICK_KEY) && en;
    assign ack_rd = rd && (bus_addr == OFS_ACK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en       <= 1'b0;
            mode     <= 1'b0;
            top_idx  <= '0;
            init_idx <= '0;
        end else if (wr) begin
            if (bus_addr == OFS_CTRL) begin
                en   <= en | bus_wdata[0];
                mode <= bus_wdata[1];
            end
            if (bus_addr == OFS_RANGE) begin
                top_idx  <= bus_wdata[IDX_W-1:0];
                init_idx <= bus_wdata[2*IDX_W-1:IDX_W];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            unique case (bus_addr)
                OFS_CTRL:          bus_rdata = {{(DATA_W-2){1'b0}}, mode, en};
                OFS_RANGE:         bus_rdata = {{(DATA_W-2*IDX_W){1'b0}}, init_idx, top_idx};
                OFS_COUNT:         bus_rdata = DATA_W'(cnt);
                OFS_STAT, OFS_ACK: bus_rdata = {{(DATA_W-1){1'b0}}, irq};
                default:           bus_rdata = '0;
            endcase
        end
    end

    // R2: the enable bit is sticky
    assert_en_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> en);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 16,
    parameter int CW        = BASE_LOG2 + NUM_PERIODS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    input  logic             zero,
    input  logic             run,
    output logic [CW-1:0]    cnt,
    output logic             expire
);

    logic [CW:0]   wide;
    logic [CW-1:0] load_val;

    // 2^(BASE_LOG2+idx) - 1, computed one bit wider so the largest period fits
    assign wide     = ((CW+1)'(1) << (BASE_LOG2 + int'(load_idx))) - (CW+1)'(1);
    assign load_val = wide[CW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (zero)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expire = run && (cnt == '0);

    // R4: one step down per running cycle
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !zero && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_set,
    input  logic kick,
    input  logic expire,
    input  logic ack_rd,
    input  logic mode,
    output logic load,
    output logic use_init,
    output logic zero,
    output logic run,
    output logic irq,
    output logic sys_rst
);

    localparam int PC_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(RST_CYCLES - 1);

    wd_state_e       state, nxt;
    logic [PC_W-1:0] pcnt;

    // State register and pulse counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            pcnt  <= '0;
        end else begin
            state <= nxt;
            pcnt  <= (state == ST_FIRING) ? pcnt + 1'b1 : '0;
        end
    end

    // Next state and counter commands
    always_comb begin
        nxt      = state;
        load     = 1'b0;
        use_init = 1'b0;
        zero     = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (en_set) begin
                    nxt      = ST_ARMED;
                    load     = 1'b1;
                    use_init = 1'b1;
                end
            end
            ST_ARMED: begin
                if (kick) begin
                    load = 1'b1;
                end else if (expire) begin
                    if (mode) begin
                        nxt  = ST_WARNED;
                        load = 1'b1;
                    end else begin
                        nxt  = ST_FIRING;
                        zero = 1'b1;
                    end
                end
            end
            ST_WARNED: begin
                if (kick) begin
                    nxt  = ST_ARMED;
                    load = 1'b1;
                end else if (expire) begin
                    nxt  = ST_FIRING;
                    zero = 1'b1;
                end else if (ack_rd) begin
                    nxt = ST_ARMED;
                end
            end
            ST_FIRING: begin
                zero = 1'b1;
                if (pcnt == PC_LAST)
                    nxt = ST_HALTED;
            end
            ST_HALTED: begin
                zero = 1'b1;
            end
            default: nxt = ST_OFF;
        endcase
    end

    // Outputs decoded from the state register
    always_comb begin
        run     = (state == ST_ARMED) || (state == ST_WARNED);
        irq     = (state == ST_WARNED);
        sys_rst = (state == ST_FIRING);
    end

    // R5: a kick while counting leaves no interrupt pending
    assert_kick_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && run) |=> !irq);

    // R7: direct-mode expiry fires reset next cycle
    assert_direct_bite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && expire && !kick && !mode) |=> sys_rst);

    // R8: second expiry with the interrupt pending fires reset
    assert_second_bite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && expire && !kick) |=> (sys_rst && !irq));

    // R10: halted is final and silent
    assert_halt_final_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALTED) |=> (state == ST_HALTED && !sys_rst && !irq));

    // R8: interrupt and reset never overlap
    assert_outputs_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && sys_rst));

endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2  = 16,
    parameter int RST_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        sys_rst
);

    localparam int CW = BASE_LOG2 + NUM_PERIODS - 1;

    logic             en, mode, en_set, kick, ack_rd;
    logic [IDX_W-1:0] top_idx, init_idx, load_idx;
    logic             load, use_init, zero, run, expire;
    logic [CW-1:0]    cnt;

    wdog_regs #(.CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt       (cnt),
        .irq       (irq),
        .bus_rdata (bus_rdata),
        .en        (en),
        .mode      (mode),
        .top_idx   (top_idx),
        .init_idx  (init_idx),
        .en_set    (en_set),
        .kick      (kick),
        .ack_rd    (ack_rd)
    );

    assign load_idx = use_init ? init_idx : top_idx;

    wdog_counter #(.BASE_LOG2(BASE_LOG2), .CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_idx (load_idx),
        .zero     (zero),
        .run      (run),
        .cnt      (cnt),
        .expire   (expire)
    );

    wdog_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_set   (en_set),
        .kick     (kick),
        .expire   (expire),
        .ack_rd   (ack_rd),
        .mode     (mode),
        .load     (load),
        .use_init (use_init),
        .zero     (zero),
        .run      (run),
        .irq      (irq),
        .sys_rst  (sys_rst)
    );

endmodule

// File: tb/wdog_twostage_tb.sv
`timescale 1ns/1ps
module wdog_twostage_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, sys_rst;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wdog_twostage #(.BASE_LOG2(3), .RST_CYCLES(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sys_rst(sys_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        @(posedge clk);
        #1;
        bus_req = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        do_reset();
        chk("R1 irq", 32'(irq), 0);
        chk("R1 sys_rst", 32'(sys_rst), 0);
        bus_rd(8'h00, d); chk("R1 ctrl", d, 0);
        bus_rd(8'h04, d); chk("R1 range", d, 0);
        bus_rd(8'h08, d); chk("R1 count", d, 0);
        bus_rd(8'h10, d); chk("R1 status", d, 0);
    endtask

    task automatic t_kick_and_index();
        logic [31:0] d;
        do_reset();
        bus_wr(8'h04, 32'h10);                 // initial idx 1 (16), period idx 0 (8)
        bus_rd(8'h04, d); chk("R3 range readback", d, 32'h10);
        bus_wr(8'h00, 32'h1);                  // enable
        bus_rd(8'h08, d); chk("R3 initial load", d, 15);
        bus_wr(8'h0C, 32'h76);
        bus_rd(8'h08, d); chk("R5 kick reload", d, 7);
        bus_wr(8'h0C, 32'h75);
        bus_rd(8'h08, d); chk("R5 wrong key ignored", d, 5);
        bus_wr(8'h00, 32'h0);
        bus_rd(8'h00, d); chk("R2 enable sticky", d, 1);
        bus_wr(8'h00, 32'h2);
        bus_rd(8'h00, d); chk("R2 mode set", d, 3);
    endtask

    task automatic t_direct_bite();
        logic [31:0] d;
        do_reset();
        bus_wr(8'h00, 32'h1);
        step(7);
        chk("R4 no early expiry", 32'(sys_rst), 0);
        step(1);
        chk("R7 direct reset", 32'(sys_rst), 1);
        chk("R7 no irq", 32'(irq), 0);
        step(7);
        chk("R10 pulse held", 32'(sys_rst), 1);
        step(1);
        chk("R10 pulse ends", 32'(sys_rst), 0);
        bus_wr(8'h0C, 32'h76);
        bus_rd(8'h08, d); chk("R10 halted count", d, 0);
        step(40);
        chk("R10 stays low", 32'(sys_rst), 0);
        chk("R10 irq low", 32'(irq), 0);
    endtask

    task automatic t_two_stage();
        logic [31:0] d;
        do_reset();
        bus_wr(8'h04, 32'h11);
        bus_wr(8'h00, 32'h3);
        step(15);
        chk("R8 irq not yet", 32'(irq), 0);
        step(1);
        chk("R8 first expiry irq", 32'(irq), 1);
        chk("R8 no reset yet", 32'(sys_rst), 0);
        bus_rd(8'h10, d); chk("R9 status pending", d, 1);
        step(14);
        chk("R8 before second expiry", 32'(sys_rst), 0);
        chk("R8 irq kept", 32'(irq), 1);
        step(1);
        chk("R8 second expiry reset", 32'(sys_rst), 1);
        chk("R8 irq dropped", 32'(irq), 0);
    endtask

    task automatic t_ack_and_kick();
        logic [31:0] d;
        do_reset();
        bus_wr(8'h00, 32'h3);
        step(8);
        chk("R8 irq at expiry", 32'(irq), 1);
        bus_rd(8'h14, d); chk("R9 ack returns status", d, 1);
        chk("R9 ack clears", 32'(irq), 0);
        step(6);
        chk("R9 no reset after ack", 32'(sys_rst), 0);
        step(1);
        chk("R9 warns again", 32'(irq), 1);
        chk("R9 still no reset", 32'(sys_rst), 0);
        bus_wr(8'h0C, 32'h76);
        chk("R5 kick clears irq", 32'(irq), 0);
        step(7);
        chk("R5 full period after kick", 32'(irq), 0);
        step(1);
        chk("R5 warns after kick period", 32'(irq), 1);
    endtask

    task automatic t_period_change();
        logic [31:0] d;
        do_reset();
        bus_wr(8'h00, 32'h1);
        bus_wr(8'h04, 32'h2);
        bus_rd(8'h08, d); chk("R6 no reload on range write", d, 6);
        bus_wr(8'h0C, 32'h76);
        bus_rd(8'h08, d); chk("R6 new period at kick", d, 31);
        bus_wr(8'h08, 32'h3);
        bus_rd(8'h08, d); chk("R11 count read-only", d, 29);
        bus_rd(8'h20, d); chk("R11 unmapped zero", d, 0);
        bus_rd(8'hFC, d); chk("R11 unmapped zero high", d, 0);
        bus_wr(8'h10, 32'h1);
        chk("R11 status write no irq", 32'(irq), 0);
        bus_rd(8'h10, d); chk("R11 status read-only", d, 0);
    endtask

    task automatic t_disabled_kick();
        logic [31:0] d;
        do_reset();
        bus_wr(8'h0C, 32'h76);
        bus_rd(8'h08, d); chk("R5 kick while off", d, 0);
        bus_rd(8'h00, d); chk("R5 still disabled", d, 0);
        step(20);
        chk("R5 off no reset", 32'(sys_rst), 0);
    endtask

    initial begin
        t_reset_state();
        t_kick_and_index();
        t_direct_bite();
        t_two_stage();
        t_ack_and_kick();
        t_period_change();
        t_disabled_kick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule